// File: doc/BRIEF.md
# Two-Slot Byte-Stream DMA Channel

This block moves a stream of bytes between system memory and a byte-wide peripheral. Software describes each buffer with a 64-bit descriptor. Each descriptor holds a start address, a byte length and a "last" flag. There are two descriptor slots, A and B, and each slot has its own valid flag. The engine starts on slot A after any reset. When a buffer is finished, the engine clears that slot's valid flag and moves to the other slot. Software can therefore refill one slot while the other drains, in ping-pong fashion.

In the memory-to-device direction, the engine reads whole memory words through a request/response port. It then hands the bytes one at a time to the device. In the device-to-memory direction, it takes bytes from the device and issues single-byte writes. A control register sets the direction, enable (freeze) and a one-shot channel reset. A read-only diagnostic register shows three things: the slot in use, whether the engine is actively running, and how many bytes of the current buffer are left. When a descriptor with the last flag drains, the engine pulses a terminal-count line to the device.

Top module: `duo_ctx_dma`

## Requirements
- R1: A configuration write with `cfg_sel` 0 loads slot A and `cfg_sel` 1 loads slot B. In the descriptor word, bits 31:0 are the start address, bits 43:32 are the byte length and bit 63 is the last flag. Bits 62:44 are ignored.
- R2: After reset the engine works on slot A. When a buffer completes, it clears that slot's valid flag and switches to the other slot. It starts there at once if that slot is valid, and otherwise waits there, even if the first slot becomes valid again.
- R3: `dev_tc` is high for exactly one cycle after the final byte of a descriptor whose last flag is 1. It never goes high for a descriptor whose last flag is 0.
- R4: Within one descriptor, the byte address increments only in its low `PAGE_BITS` bits. The bits above never change, so a buffer that runs past the top of its page wraps to the bottom of the same page.
- R5: In the memory-to-device direction, the start address may have any byte alignment. Bytes reach `dev_dout` in address order. Byte k of a fetched word (bits 8k+7:8k) is the byte at word address + k. At most one read is outstanding.
- R6: In the device-to-memory direction, the low `ALIGN_BITS` bits of the start address are treated as zero. Byte n of the buffer is written to that aligned address advanced n times under R4.
- R7: Control write (`cfg_sel` 2) bit 0 sets the direction: 0 is memory to device, 1 is device to memory. In the second case, each accepted `dev_din` byte appears on `mem_wbyte` one cycle later with `mem_we` high.
- R8: Control bit 1 is the enable. While it is 0, no byte moves, no new read is issued, and the remaining count and address hold their values.
- R9: A control write with bit 2 set clears both valid flags, the enable, the direction and the remaining count, and returns the engine to idle on slot A. Hardware reset leaves `ctrl_q`, `diag_q`, `mem_req`, `mem_we` and `dev_tc` at zero.
- R10: `ctrl_q` bits are: 0 direction, 1 enable, 2 always 0, 3 slot B valid, 4 slot A valid. Control writes set bits 3 and 4. `diag_q` bits are: 0 slot in use (1 = B), 1 engine enabled and holding a loaded descriptor, 13:2 bytes remaining.
- R11: The remaining count loads from the length and drops by one for each byte moved. A descriptor moves exactly as many bytes as its length.
- R12: A length of zero completes the descriptor with no byte moved, and still gives the R3 pulse when the last flag is 1.
- R13: A byte moves (`dev_take` high) only in a cycle with `dev_ready` high. `dev_ready` low stalls the buffer with its count intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Write target: 0 slot A, 1 slot B, 2 control, 3 ignored |
| cfg_wdata | input | 64 | Descriptor word or control value |
| ctrl_q | output | 5 | Control/status readback |
| diag_q | output | 14 | Diagnostic readback |
| mem_req | output | 1 | One-cycle memory word read request |
| mem_addr | output | 32 | Word-aligned byte address of the read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 8*WORD_BYTES | Read data word |
| mem_we | output | 1 | Byte write strobe |
| mem_waddr | output | 32 | Byte write address |
| mem_wbyte | output | 8 | Byte write data |
| dev_ready | input | 1 | Device can give or take a byte this cycle |
| dev_din | input | 8 | Byte from the device |
| dev_take | output | 1 | A byte moves this cycle |
| dev_dout | output | 8 | Byte to the device |
| dev_tc | output | 1 | Terminal-count pulse |

## Verification
The bench builds the block with `WORD_BYTES`=4, `PAGE_BITS`=6 and `ALIGN_BITS`=3. With these values, word boundaries, page wrap and input alignment masking all occur within buffers of only a few bytes. This makes a full sweep practical: every start offset from 0 to 7 is crossed with every length from 0 to 9, in both directions and under two device-ready patterns. All expected bytes and addresses are computed arithmetically.

// File: rtl/dcd_pkg.sv
package dcd_pkg;
  localparam int ADDR_W   = 32;
  localparam int LEN_W    = 12;
  localparam int LEN_LSB  = 32;
  localparam int LAST_BIT = 63;

  localparam int C_DIR = 0;
  localparam int C_EN  = 1;
  localparam int C_RST = 2;
  localparam int C_VB  = 3;
  localparam int C_VA  = 4;

  localparam logic [1:0] SEL_CTRL = 2'd2;

  typedef struct packed {
    logic              last;
    logic [LEN_W-1:0]  len;
    logic [ADDR_W-1:0] base;
  } desc_t;

  typedef enum logic {ST_LOAD = 1'b0, ST_RUN = 1'b1} eng_st_t;

  function automatic desc_t unpack_desc(input logic [63:0] w);
    desc_t d;
    d.last = w[LAST_BIT];
    d.len  = w[LEN_LSB +: LEN_W];
    d.base = w[ADDR_W-1:0];
    return d;
  endfunction
endpackage

// File: rtl/dcd_regs.sv
module dcd_regs
  import dcd_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_sel,
  input  logic [63:0] cfg_wdata,
  input  logic [1:0]  done_clr,
  output desc_t       desc_a,
  output desc_t       desc_b,
  output logic [1:0]  vld,
  output logic        en,
  output logic        dir,
  output logic        soft_rst
);
  desc_t slot_q [2];
  logic  ctrl_wr;

  assign ctrl_wr  = cfg_we && (cfg_sel == SEL_CTRL);
  assign soft_rst = ctrl_wr && cfg_wdata[C_RST];

  for (genvar s = 0; s < 2; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) slot_q[s] <= '0;
      else if (cfg_we && cfg_sel == 2'(s)) slot_q[s] <= unpack_desc(cfg_wdata);
    end
  end

  assign desc_a = slot_q[0];
  assign desc_b = slot_q[1];

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      dir <= 1'b0;
      en  <= 1'b0;
      vld <= 2'b00;
    end else if (ctrl_wr) begin
      dir <= cfg_wdata[C_DIR];
      en  <= cfg_wdata[C_EN];
      vld <= {cfg_wdata[C_VB], cfg_wdata[C_VA]};
    end else begin
      vld <= vld & ~done_clr;
    end
  end

  AST_RST_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (vld == 2'b00 && !en && !dir)); // R9
endmodule

// File: rtl/dcd_fetch.sv
module dcd_fetch
  import dcd_pkg::*;
#(
  parameter int WORD_BYTES = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    flush,
  input  logic                    want,
  input  logic                    take,
  input  logic [ADDR_W-1:0]       byte_addr,
  input  logic                    mem_rvalid,
  input  logic [8*WORD_BYTES-1:0] mem_rdata,
  output logic                    mem_req,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic                    have_word,
  output logic [7:0]              cur_byte
);
  localparam int OFF_W  = $clog2(WORD_BYTES);
  localparam int WORD_W = 8 * WORD_BYTES;

  logic              pend_q;
  logic [WORD_W-1:0] word_q;
  logic              issue;

  assign issue = want && !have_word && !pend_q;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      mem_req   <= 1'b0;
      pend_q    <= 1'b0;
      have_word <= 1'b0;
    end else begin
      mem_req <= 1'b0;
      if (issue) begin
        mem_req <= 1'b1;
        pend_q  <= 1'b1;
      end
      if (pend_q && mem_rvalid) begin
        pend_q    <= 1'b0;
        have_word <= 1'b1;
      end else if (take && (&byte_addr[OFF_W-1:0])) begin
        have_word <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (issue) mem_addr <= {byte_addr[ADDR_W-1:OFF_W], OFF_W'(0)};
    if (pend_q && mem_rvalid) word_q <= mem_rdata;
  end

  assign cur_byte = word_q[{byte_addr[OFF_W-1:0], 3'b000} +: 8];

  AST_SINGLE_READ: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req); // R5
endmodule

// File: rtl/dcd_engine.sv
module dcd_engine
  import dcd_pkg::*;
#(
  parameter int PAGE_BITS  = 12,
  parameter int ALIGN_BITS = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic              en,
  input  logic              dir,
  input  logic [1:0]        vld,
  input  desc_t             desc_a,
  input  desc_t             desc_b,
  input  logic              dev_ready,
  input  logic [7:0]        dev_din,
  input  logic              have_word,
  output logic              dev_take,
  output logic              dev_tc,
  output logic              want,
  output logic              flush,
  output logic [1:0]        done_clr,
  output logic [ADDR_W-1:0] addr_q,
  output logic [LEN_W-1:0]  rem_q,
  output logic              cur_q,
  output logic              active,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [7:0]        mem_wbyte
);
  eng_st_t           st_q;
  logic              last_q;
  desc_t             cur_d;
  logic              finish;
  logic [ADDR_W-1:0] next_addr;

  assign cur_d     = cur_q ? desc_b : desc_a;
  assign active    = (st_q == ST_RUN) && en;
  assign dev_take  = active && (rem_q != '0) && dev_ready && (dir || have_word);
  assign want      = active && !dir && (rem_q != '0);
  assign finish    = active && (rem_q == '0);
  assign done_clr  = finish ? (cur_q ? 2'b10 : 2'b01) : 2'b00;
  assign flush     = finish || soft_rst;
  assign next_addr = {addr_q[ADDR_W-1:PAGE_BITS], addr_q[PAGE_BITS-1:0] + PAGE_BITS'(1)};

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      st_q   <= ST_LOAD;
      cur_q  <= 1'b0;
      rem_q  <= '0;
      addr_q <= '0;
      last_q <= 1'b0;
      dev_tc <= 1'b0;
      mem_we <= 1'b0;
    end else begin
      dev_tc <= 1'b0;
      mem_we <= 1'b0;
      case (st_q)
        ST_LOAD: begin
          if (en && vld[cur_q]) begin
            addr_q <= dir ? {cur_d.base[ADDR_W-1:ALIGN_BITS], ALIGN_BITS'(0)} : cur_d.base;
            rem_q  <= cur_d.len;
            last_q <= cur_d.last;
            st_q   <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (finish) begin
            dev_tc <= last_q;
            cur_q  <= ~cur_q;
            st_q   <= ST_LOAD;
          end else if (dev_take) begin
            rem_q  <= rem_q - LEN_W'(1);
            addr_q <= next_addr;
            mem_we <= dir;
          end
        end
        default: st_q <= ST_LOAD;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (dev_take) begin
      mem_waddr <= addr_q;
      mem_wbyte <= dev_din;
    end
  end

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (dev_take && !soft_rst) |=> rem_q == $past(rem_q) - LEN_W'(1)); // R11
  AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (dev_take && !soft_rst) |=> addr_q[ADDR_W-1:PAGE_BITS] == $past(addr_q[ADDR_W-1:PAGE_BITS])); // R4
  AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RUN && !en && !soft_rst) |=> ($stable(rem_q) && $stable(addr_q))); // R8
  AST_TC_SINGLE: assert property (@(posedge clk) disable iff (rst)
    dev_tc |=> !dev_tc); // R3
  AST_TAKE_READY: assert property (@(posedge clk) disable iff (rst)
    dev_take |-> (dev_ready && en)); // R13
  AST_SOFT_RST_IDLE: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (rem_q == '0 && st_q == ST_LOAD && !cur_q && !dev_tc)); // R9
  AST_IN_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_LOAD && en && vld[cur_q] && dir && !soft_rst) |=> addr_q[ALIGN_BITS-1:0] == '0); // R6
endmodule

// File: rtl/duo_ctx_dma.sv
module duo_ctx_dma
  import dcd_pkg::*;
#(
  parameter int WORD_BYTES = 8,
  parameter int PAGE_BITS  = 12,
  parameter int ALIGN_BITS = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfg_we,
  input  logic [1:0]              cfg_sel,
  input  logic [63:0]             cfg_wdata,
  output logic [4:0]              ctrl_q,
  output logic [13:0]             diag_q,
  output logic                    mem_req,
  output logic [31:0]             mem_addr,
  input  logic                    mem_rvalid,
  input  logic [8*WORD_BYTES-1:0] mem_rdata,
  output logic                    mem_we,
  output logic [31:0]             mem_waddr,
  output logic [7:0]              mem_wbyte,
  input  logic                    dev_ready,
  input  logic [7:0]              dev_din,
  output logic                    dev_take,
  output logic [7:0]              dev_dout,
  output logic                    dev_tc
);
  desc_t             desc_a, desc_b;
  logic [1:0]        vld, done_clr;
  logic              en, dir, soft_rst;
  logic              want, flush, have_word, cur_q, active;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  rem_q;

  dcd_regs u_regs (
    .clk, .rst, .cfg_we, .cfg_sel, .cfg_wdata, .done_clr,
    .desc_a, .desc_b, .vld, .en, .dir, .soft_rst
  );

  dcd_engine #(.PAGE_BITS(PAGE_BITS), .ALIGN_BITS(ALIGN_BITS)) u_engine (
    .clk, .rst, .soft_rst, .en, .dir, .vld, .desc_a, .desc_b,
    .dev_ready, .dev_din, .have_word, .dev_take, .dev_tc, .want, .flush,
    .done_clr, .addr_q, .rem_q, .cur_q, .active, .mem_we, .mem_waddr, .mem_wbyte
  );

  dcd_fetch #(.WORD_BYTES(WORD_BYTES)) u_fetch (
    .clk, .rst, .flush, .want, .take(dev_take), .byte_addr(addr_q),
    .mem_rvalid, .mem_rdata, .mem_req, .mem_addr, .have_word, .cur_byte(dev_dout)
  );

  assign ctrl_q = {vld[0], vld[1], 1'b0, en, dir};
  assign diag_q = {rem_q, active, cur_q};
endmodule

// File: tb/duo_ctx_dma_bench.sv
module duo_ctx_dma_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WB = 4;
  localparam int PB = 6;
  localparam int AB = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_sel = 2'd3;
  logic [63:0]   cfg_wdata = '0;
  logic [4:0]    ctrl_q;
  logic [13:0]   diag_q;
  logic          mem_req, mem_we, dev_take, dev_tc;
  logic [31:0]   mem_addr, mem_waddr;
  logic          mem_rvalid = 1'b0;
  logic [WB*8-1:0] mem_rdata = '0;
  logic [7:0]    mem_wbyte, dev_dout;
  logic          dev_ready = 1'b0;
  logic [7:0]    dev_din = '0;

  duo_ctx_dma #(.WORD_BYTES(WB), .PAGE_BITS(PB), .ALIGN_BITS(AB)) u_duo_ctx_dma (
    .clk, .rst, .cfg_we, .cfg_sel, .cfg_wdata, .ctrl_q, .diag_q,
    .mem_req, .mem_addr, .mem_rvalid, .mem_rdata, .mem_we, .mem_waddr, .mem_wbyte,
    .dev_ready, .dev_din, .dev_take, .dev_dout, .dev_tc
  );

  int n_cmp = 0, n_bad = 0;
  int takes = 0, writes = 0, tcs = 0, ready_mode = 0, cyc = 0;
  bit data_chk = 1'b1, cur_dir = 1'b0, exp_slot = 1'b0;
  logic [31:0] exp_rd = '0, exp_wr = '0;

  function automatic logic [7:0] mb(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction
  function automatic logic [31:0] nxt(input logic [31:0] a);
    return {a[31:PB], a[PB-1:0] + PB'(1)};
  endfunction
  function automatic logic [7:0] dseq(input int k);
    return 8'(k * 13 + 7);
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // inputs change just after the rising edge
  always @(posedge clk) begin
    #1;
    cyc++;
    mem_rvalid = mem_req;
    if (mem_req) for (int i = 0; i < WB; i++) mem_rdata[i*8 +: 8] = mb(mem_addr + 32'(i));
    dev_ready = (ready_mode == 0) ? 1'b1 : (ready_mode == 1) ? (cyc % 3 != 2) : 1'b0;
    dev_din = dseq(takes);
  end

  // outputs sampled at the falling edge
  always @(negedge clk) begin
    if (!rst) begin
      if (dev_take) begin
        if (data_chk && !cur_dir) begin
          chk(dev_dout == mb(exp_rd), "R5 output byte", dev_dout, mb(exp_rd));
          exp_rd = nxt(exp_rd);
        end
        takes++;
      end
      if (mem_we) begin
        if (data_chk) begin
          chk(mem_waddr == exp_wr, "R6 R4 write address", mem_waddr, exp_wr);
          chk(mem_wbyte == dseq(writes), "R7 write data", mem_wbyte, dseq(writes));
          exp_wr = nxt(exp_wr);
        end
        writes++;
      end
      if (dev_tc) tcs++;
    end
  end

  task automatic wr(input logic [1:0] sel, input logic [63:0] d);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_sel = 2'd3;
  endtask

  function automatic logic [63:0] mkdesc(input logic [31:0] base, input int len, input bit last);
    return {last, 19'h5A5A5, 12'(len), base};
  endfunction

  task automatic wait_clear(input int bitpos);
    int guard = 0;
    while (ctrl_q[bitpos] && guard < 3000) begin @(negedge clk); guard++; end
    repeat (3) @(negedge clk);
  endtask

  task automatic run_desc(input logic [31:0] base, input int len, input bit last, input bit dir,
                          input string tag);
    logic [4:0] c;
    wr(exp_slot ? 2'd1 : 2'd0, mkdesc(base, len, last));
    exp_rd = base; exp_wr = {base[31:AB], AB'(0)};
    takes = 0; writes = 0; tcs = 0; data_chk = 1'b1; cur_dir = dir;
    chk(diag_q[0] == exp_slot, {tag, " R2 slot in use"}, diag_q[0], exp_slot);
    c = 5'b00010 | 5'(dir) | (exp_slot ? 5'b01000 : 5'b10000);
    wr(2'd2, 64'(c));
    wait_clear(exp_slot ? 3 : 4);
    chk(takes == len, {tag, " R1 R11 bytes moved"}, takes, len);
    if (dir) chk(writes == len, {tag, " R7 bytes written"}, writes, len);
    chk(tcs == int'(last), {tag, " R3 R12 terminal count"}, tcs, last);
    chk(diag_q[13:2] == 0, {tag, " R10 count drained"}, diag_q[13:2], 0);
    exp_slot = !exp_slot;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(ctrl_q == 0, "R9 reset ctrl", ctrl_q, 0);
    chk(diag_q == 0, "R9 reset diag", diag_q, 0);
    chk(!mem_req && !mem_we && !dev_tc, "R9 reset outputs", {mem_req, mem_we, dev_tc}, 0);

    // page wrap in both directions
    run_desc(32'h5000_013E, 4, 1'b1, 1'b0, "R4 out wrap");
    run_desc(32'h0000_01F9, 10, 1'b0, 1'b1, "R4 in wrap");

    // sweeps over offset and length
    for (int dir = 0; dir < 2; dir++)
      for (int off = 0; off < 8; off++)
        for (int len = 0; len < 10; len++) begin
          ready_mode = len % 2;
          run_desc(32'h0000_6000 + 32'(dir * 32'h100) + 32'(off), len, bit'((off + len) % 2),
                   bit'(dir), dir ? "R6 in sweep" : "R5 out sweep");
        end

    // handshake stall, then freeze
    ready_mode = 2;
    wr(exp_slot ? 2'd1 : 2'd0, mkdesc(32'h0000_2005, 8, 1'b0));
    exp_rd = 32'h2005; takes = 0; tcs = 0; data_chk = 1'b1; cur_dir = 1'b0;
    wr(2'd2, 64'(5'b00010 | (exp_slot ? 5'b01000 : 5'b10000)));
    repeat (6) @(negedge clk);
    chk(takes == 0, "R13 no byte without ready", takes, 0);
    chk(diag_q == {12'd8, 1'b1, exp_slot}, "R10 diag while loaded", diag_q, {12'd8, 1'b1, exp_slot});
    wr(2'd2, 64'(exp_slot ? 5'b01000 : 5'b10000));
    ready_mode = 0;
    repeat (8) @(negedge clk);
    chk(takes == 0, "R8 frozen moves nothing", takes, 0);
    chk(diag_q[13:2] == 8, "R8 count held", diag_q[13:2], 8);
    chk(diag_q[1] == 0, "R10 inactive when frozen", diag_q[1], 0);
    wr(2'd2, 64'(5'b00010 | (exp_slot ? 5'b01000 : 5'b10000)));
    wait_clear(exp_slot ? 3 : 4);
    chk(takes == 8, "R8 resumes after enable", takes, 8);
    exp_slot = !exp_slot;

    // channel reset mid-buffer
    ready_mode = 1;
    wr(exp_slot ? 2'd1 : 2'd0, mkdesc(32'h0000_3000, 40, 1'b1));
    exp_rd = 32'h3000; takes = 0; tcs = 0;
    wr(2'd2, 64'(5'b00010 | (exp_slot ? 5'b01000 : 5'b10000)));
    for (int g = 0; g < 200 && takes < 5; g++) @(negedge clk);
    wr(2'd2, 64'h4);
    chk(ctrl_q == 0, "R9 soft reset ctrl", ctrl_q, 0);
    chk(diag_q == 0, "R9 soft reset diag", diag_q, 0);
    chk(tcs == 0, "R9 no tc on reset", tcs, 0);
    exp_slot = 1'b0;

    // slot ordering after reset: waits on A
    ready_mode = 0; data_chk = 1'b0; cur_dir = 1'b0;
    wr(2'd1, mkdesc(32'h0000_4000, 3, 1'b1));
    wr(2'd0, mkdesc(32'h0000_4100, 2, 1'b1));
    takes = 0; tcs = 0;
    wr(2'd2, 64'(5'b01010));
    repeat (10) @(negedge clk);
    chk(takes == 0, "R2 waits on invalid slot A", takes, 0);
    chk(diag_q[0] == 0, "R2 starts at A", diag_q[0], 0);
    wr(2'd2, 64'(5'b11010));
    for (int g = 0; g < 200 && ctrl_q[4:3] != 0; g++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(takes == 5, "R2 A then B", takes, 5);
    chk(tcs == 2, "R3 one pulse per last", tcs, 2);
    chk(diag_q[0] == 0, "R2 back to A", diag_q[0], 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule